// File: doc/BRIEF.md
# Streaming Sample Gain Scaler

This block scales a stream of signed 16-bit audio samples by a programmable unsigned coefficient. The coefficient is in fixed-point form with 14 fractional bits, so the value 0x4000 is unity gain. Software works out the coefficient for a wanted gain in decibels as 16384 × 10^(dB/20), rounded to the nearest integer. For example, about 0x0082 gives close to -42 dB. The block sits on a transmit path ahead of any filter stage. It takes one sample per valid cycle and returns the scaled sample exactly one clock later.

Each product is rounded half-up to the integer scale and limited to the signed 16-bit range. When a result has to be limited, a saturation flag is set and stays set. Software clears the flag by writing a one, and reset also clears it. A new coefficient can be written at any time. It applies from the first sample accepted after the write cycle.

Top module: `gain_scaler`

## Requirements
- R1: After reset, outValid is 0, outData is 0x0000, satFlag is 0, and the coefficient is 0x4000.
- R2: outValid is 1 in exactly the cycle after a cycle with inValid = 1, and 0 otherwise.
- R3: For input x and coefficient c (unsigned), outData equals floor((x·c + 8192) / 16384), limited to -32768..32767.
- R4: With coefficient 0x4000, every input value, -32768 and 32767 included, comes out unchanged and does not set satFlag.
- R5: Rounding is half-up: x=1 with c=0x2000 gives 1, x=-1 gives 0, x=3 gives 2, and x=-3 gives -1.
- R6: Results above 32767 come out as 0x7FFF, and results below -32768 come out as 0x8000.
- R7: satFlag goes to 1 at the same clock edge that presents a limited result. It then stays 1 through later samples that are not limited.
- R8: A clear write (satClrWr = 1) with satClrBit = 1 sets satFlag to 0 at the next edge. A write with satClrBit = 0 leaves it unchanged.
- R9: If a clear write and a limited result happen in the same cycle, satFlag stays 1.
- R10: A sample accepted in the same cycle as a coefficient write uses the old coefficient. Later samples use the new one.
- R11: outData holds its last value in cycles that follow a cycle with no input valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input sample valid |
| inData | input | 16 | Signed input sample |
| outValid | output | 1 | Output sample valid, one clock after inValid |
| outData | output | 16 | Signed scaled sample |
| coefWrEn | input | 1 | Coefficient register write strobe |
| coefWrData | input | 16 | Unsigned Q2.14 coefficient |
| satClrWr | input | 1 | Status write strobe |
| satClrBit | input | 1 | Status write data; 1 clears the flag |
| satFlag | output | 1 | Sticky saturation status |

## Verification
The bench uses the default widths: 16-bit samples and a 16-bit coefficient with 14 fractional bits. With these widths the largest coefficient is just under 4× gain, so both the positive and the negative limit can be reached with ordinary sample values. The same widths also allow the exact -32768 corner at unity gain to be tested without any limiting. A behavioural model computes every result in 64-bit integers. It is compared against the ports on every clock through directed corners and a long pseudo-random run. That run mixes coefficient writes, clear writes and idle cycles.

// File: rtl/gs_pkg.sv
package gs_pkg;
  // Strobes the control sends to the datapath each cycle
  typedef struct packed {
    logic capture;   // compute and register a new output sample
    logic coefLoad;  // load the coefficient register
  } gsStrobes_t;
endpackage

// File: rtl/gs_datapath.sv
module gs_datapath
  import gs_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int FRAC_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  gsStrobes_t        strobes,
  input  logic [DATA_W-1:0] inData,
  input  logic [COEF_W-1:0] coefWrData,
  output logic [DATA_W-1:0] outData,
  output logic              clampHit
);
  localparam int PROD_W = DATA_W + COEF_W + 1;
  localparam logic [COEF_W-1:0] UNITY =
    {{(COEF_W-FRAC_W-1){1'b0}}, 1'b1, {FRAC_W{1'b0}}};
  localparam logic signed [PROD_W-1:0] ROUND_BIAS =
    {{(PROD_W-FRAC_W){1'b0}}, 1'b1, {(FRAC_W-1){1'b0}}};
  localparam logic signed [PROD_W-1:0] OUT_MAX =
    {{(COEF_W+2){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [PROD_W-1:0] OUT_MIN =
    {{(COEF_W+2){1'b1}}, {(DATA_W-1){1'b0}}};

  logic [COEF_W-1:0]        coefReg;
  logic signed [PROD_W-1:0] sampleExt, coefExt, product, biased, scaled;
  logic                     overHi, underLo;
  logic [DATA_W-1:0]        limited;

  always_ff @(posedge clk) begin
    if (!rstN) coefReg <= UNITY;
    else if (strobes.coefLoad) coefReg <= coefWrData;
  end

  always_comb begin
    sampleExt = {{(COEF_W+1){inData[DATA_W-1]}}, inData};
    coefExt   = {{(DATA_W+1){1'b0}}, coefReg};
    product   = sampleExt * coefExt;
    biased    = product + ROUND_BIAS;
    scaled    = biased >>> FRAC_W;
    overHi    = scaled > OUT_MAX;
    underLo   = scaled < OUT_MIN;
    if (overHi)       limited = OUT_MAX[DATA_W-1:0];
    else if (underLo) limited = OUT_MIN[DATA_W-1:0];
    else              limited = scaled[DATA_W-1:0];
  end

  assign clampHit = overHi | underLo;

  always_ff @(posedge clk) begin
    if (!rstN) outData <= '0;
    else if (strobes.capture) outData <= limited;
  end

  // R4
  unity_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && coefReg == UNITY) |=> outData == $past(inData));
  // R11
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> $stable(outData));
  // R6
  top_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && overHi) |=> outData == OUT_MAX[DATA_W-1:0]);
  // R6
  bottom_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && underLo) |=> outData == OUT_MIN[DATA_W-1:0]);
endmodule

// File: rtl/gs_ctrl.sv
module gs_ctrl
  import gs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       coefWrEn,
  input  logic       satClrWr,
  input  logic       satClrBit,
  input  logic       clampHit,
  output gsStrobes_t strobes,
  output logic       outValid,
  output logic       satFlag
);
  logic clearReq;

  assign strobes.capture  = inValid;
  assign strobes.coefLoad = coefWrEn;
  assign clearReq         = satClrWr & satClrBit;

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                     satFlag <= 1'b0;
    else if (inValid && clampHit)  satFlag <= 1'b1;
    else if (clearReq)             satFlag <= 1'b0;
  end

  // R2
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  // R2
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  // R7
  sat_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && clampHit) |=> satFlag);
  // R7
  sat_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (satFlag && !clearReq) |=> satFlag);
  // R8
  sat_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clearReq && !(inValid && clampHit)) |=> !satFlag);
endmodule

// File: rtl/gain_scaler.sv
module gain_scaler
  import gs_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int FRAC_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  input  logic              coefWrEn,
  input  logic [COEF_W-1:0] coefWrData,
  input  logic              satClrWr,
  input  logic              satClrBit,
  output logic              satFlag
);
  gsStrobes_t strobes;
  logic       clampHit;

  gs_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .coefWrEn  (coefWrEn),
    .satClrWr  (satClrWr),
    .satClrBit (satClrBit),
    .clampHit  (clampHit),
    .strobes   (strobes),
    .outValid  (outValid),
    .satFlag   (satFlag)
  );

  gs_datapath #(
    .DATA_W (DATA_W),
    .COEF_W (COEF_W),
    .FRAC_W (FRAC_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .inData     (inData),
    .coefWrData (coefWrData),
    .outData    (outData),
    .clampHit   (clampHit)
  );
endmodule

// File: tb/tb_gain_scaler.sv
module tb_gain_scaler;
  logic        clk = 1'b0;
  logic        rstN;
  logic        inValid;
  logic [15:0] inData;
  logic        outValid;
  logic [15:0] outData;
  logic        coefWrEn;
  logic [15:0] coefWrData;
  logic        satClrWr;
  logic        satClrBit;
  logic        satFlag;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // behavioural reference state
  int mCoef, mData;
  bit mValid, mSat;

  always #5 clk = ~clk;

  gain_scaler dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .outValid(outValid), .outData(outData), .coefWrEn(coefWrEn),
    .coefWrData(coefWrData), .satClrWr(satClrWr), .satClrBit(satClrBit),
    .satFlag(satFlag)
  );

  function automatic longint rawScale(int x, int c);
    longint p = longint'(x) * longint'(c);
    return (p + 64'sd8192) >>> 14;
  endfunction

  function automatic int refScale(int x, int c);
    longint r = rawScale(x, c);
    if (r > 32767) return 32767;
    if (r < -32768) return -32768;
    return int'(r);
  endfunction

  function automatic bit refClamp(int x, int c);
    longint r = rawScale(x, c);
    return (r > 32767) || (r < -32768);
  endfunction

  task automatic checkAll(string tag);
    checks++;
    if (outValid !== mValid) begin
      failures++;
      $display("FAIL %s outValid actual=%0b expected=%0b", tag, outValid, mValid);
    end
    checks++;
    if (int'($signed(outData)) != mData) begin
      failures++;
      $display("FAIL %s outData actual=%0d expected=%0d", tag, $signed(outData), mData);
    end
    checks++;
    if (satFlag !== mSat) begin
      failures++;
      $display("FAIL %s satFlag actual=%0b expected=%0b", tag, satFlag, mSat);
    end
  endtask

  task automatic step(bit iv, int x, bit cw, int c, bit sw, bit sb, string tag);
    bit nextSat;
    inValid = iv; inData = 16'(x);
    coefWrEn = cw; coefWrData = 16'(c);
    satClrWr = sw; satClrBit = sb;
    nextSat = mSat;
    if (sw && sb) nextSat = 0;
    if (iv && refClamp(x, mCoef)) nextSat = 1;
    if (iv) mData = refScale(x, mCoef);
    mValid = iv;
    mSat = nextSat;
    if (cw) mCoef = c;
    @(posedge clk);
    @(negedge clk);
    checkAll(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rstN = 0; inValid = 0; inData = '0; coefWrEn = 0; coefWrData = '0;
    satClrWr = 0; satClrBit = 0;
    mCoef = 16'h4000; mData = 0; mValid = 0; mSat = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    checkAll("R1 reset state");

    // default coefficient is unity
    step(1, 1234, 0, 0, 0, 0, "R1 R4 default unity");
    step(0, 0, 0, 0, 0, 0, "R2 R11 idle hold");
    step(1, -32768, 0, 0, 0, 0, "R4 min unity");
    step(1, 32767, 0, 0, 0, 0, "R4 max unity");
    step(1, -1, 0, 0, 0, 0, "R4 minus one");
    step(0, 0, 0, 0, 0, 0, "R11 hold");

    // coefficient change in the same cycle as a sample
    step(1, 100, 1, 16'h2000, 0, 0, "R10 old coef");
    step(1, 100, 0, 0, 0, 0, "R10 new coef");

    // rounding half-up
    step(1, 1, 0, 0, 0, 0, "R5 +1");
    step(1, -1, 0, 0, 0, 0, "R5 -1");
    step(1, 3, 0, 0, 0, 0, "R5 +3");
    step(1, -3, 0, 0, 0, 0, "R5 -3");

    // roughly -42 dB
    step(0, 0, 1, 16'h0082, 0, 0, "R10 coef write idle");
    step(1, 10000, 0, 0, 0, 0, "R3 small gain");
    step(1, -20000, 0, 0, 0, 0, "R3 small gain neg");

    // limiting and sticky status
    step(0, 0, 1, 16'h8000, 0, 0, "R10 coef 2x");
    step(1, 20000, 0, 0, 0, 0, "R6 R7 top limit");
    step(1, 100, 0, 0, 0, 0, "R7 sticky");
    step(0, 0, 0, 0, 1, 0, "R8 write zero keeps");
    step(0, 0, 0, 0, 1, 1, "R8 clear");
    step(1, -30000, 0, 0, 0, 0, "R6 R7 bottom limit");
    step(1, 30000, 0, 0, 1, 1, "R9 clear with limit");
    step(0, 0, 0, 0, 1, 1, "R8 clear again");
    step(1, -32768, 1, 16'h4000, 0, 0, "R6 R10 limit old coef");
    step(0, 0, 0, 0, 1, 1, "R8 clear");
    step(1, -32768, 0, 0, 0, 0, "R4 no sat at unity");

    // pseudo-random sweep
    for (int i = 0; i < 2000; i++) begin
      bit iv = ($urandom % 4) != 0;
      bit cw = ($urandom % 8) == 0;
      bit sw = ($urandom % 6) == 0;
      bit sb = $urandom % 2;
      int x = int'($signed(16'($urandom)));
      int c = int'($urandom % 65536);
      step(iv, x, cw, c, sw, sb, "R3 sweep");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule